// File: doc/BRIEF.md
# Frequency-Change Recovery Watchdog

This block guards a clock synthesizer against a bad frequency change. When software writes a new frequency selection, or turns on the programmable multiplier/divider mode, the block captures the new software frequency code and starts a countdown. The length of the countdown comes from a 4-bit field that holds whole seconds. Software confirms that the system survived the change by writing that field back to zero. If no confirmation arrives before the countdown ends, the block pulls the system reset line low for a fixed interval and raises an alarm flag. It also moves the frequency selection back to either the strap-latched hardware code or the last software code, as a policy bit decides.

Time is measured in pulses of an external timebase tick. The `TICKS_PER_SEC` parameter sets how many ticks make one second, and `PULSE_TICKS` sets how many ticks the reset pulse lasts (six milliseconds in the target system). A bench can therefore shrink both intervals. The block has no streaming interface. All pins are plain control or status levels and single-cycle strobes, so no back-pressure rules apply.

Top module: `fcr_watchdog`

## Requirements
- R1: After reset, `rst_pulldown` is 0, `alarm` is 0, `use_sw` is 0 and `freq_code` equals `hw_code`.
- R2: A change event (`sel_write` or `prog_enable` high for one cycle) while `tmo_field` is nonzero starts a countdown. The countdown expires on the clock edge that samples the (`tmo_field` × `TICKS_PER_SEC`)-th tick after the event.
- R3: `prog_enable` arms the countdown exactly as `sel_write` does.
- R4: While `tmo_field` is 0 the countdown is stopped. A countdown stopped this way never expires, even if the field later becomes nonzero without a new event, and the software code stays selected.
- R5: A change event while `tmo_field` is 0 switches the output to the software code but starts no countdown, so no reset pulse ever follows it.
- R6: `alarm` rises on the expiry edge and stays 1 until an edge samples `tmo_field` equal to 0, which clears it.
- R7: On expiry `rst_pulldown` (1 = drive the open-drain reset low) becomes 1 and stays 1 for exactly `PULSE_TICKS` further ticks. It changes only on a tick.
- R8: On expiry `use_sw` takes the value of `revert_last`. With 0, `freq_code` returns to `hw_code`. With 1, it holds the last captured software code.
- R9: A change event while a countdown is running restarts it from the value in `tmo_field`.
- R10: Each change event captures `sw_code`. While `use_sw` is 1, `freq_code` shows that captured value, whatever `sw_code` does later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| tick | input | 1 | Timebase pulse, one cycle wide |
| tmo_field | input | TMO_W | Timeout in seconds, 0 = off / disarm |
| revert_last | input | 1 | Rollback policy: 0 = hardware code, 1 = last software code |
| sel_write | input | 1 | Strobe: software frequency select written |
| prog_enable | input | 1 | Strobe: programmable frequency mode enabled |
| hw_code | input | CODE_W | Strap-latched hardware frequency code |
| sw_code | input | CODE_W | Software frequency code |
| rst_pulldown | output | 1 | 1 = pull the open-drain system reset low |
| alarm | output | 1 | Timeout alarm status |
| use_sw | output | 1 | 1 = software code selected |
| freq_code | output | CODE_W | Selected frequency code |

## Verification
Every result is registered once. `use_sw` and the captured code therefore show up one edge after a change event. `alarm`, `rst_pulldown` and the rollback all appear on the same edge that samples the expiring tick, and the alarm clears on the edge that samples a zero field. The bench changes inputs on the falling edge, applies each tick for exactly one rising edge, and reads the outputs on the next falling edge. This lets it count ticks exactly: the expiry must come on tick number timeout × `TICKS_PER_SEC` and on no earlier tick. The pulse must end after exactly `PULSE_TICKS` further ticks. The bench sweeps every timeout value under both rollback policies and alternates between the two event strobes.

// File: rtl/fcrw_pkg.sv
package fcrw_pkg;

  // Which frequency code drives the synthesizer.
  typedef enum logic {
    SRC_STRAP = 1'b0,
    SRC_SOFT  = 1'b1
  } code_src_e;

  // Source selected after a timeout, from the rollback policy bit.
  function automatic code_src_e rollback_src(input logic keep_soft);
    return keep_soft ? SRC_SOFT : SRC_STRAP;
  endfunction

endpackage

// File: rtl/fcrw_countdown.sv
module fcrw_countdown #(
  parameter int TMO_W         = 4,
  parameter int TICKS_PER_SEC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic [TMO_W-1:0] start_sec,
  output logic             running,
  output logic             expire
);

  logic [TMO_W-1:0] sec_left;
  logic             sub_zero;
  logic             advance;
  logic             sub_reload;
  logic             sub_dec;

  assign advance    = running & tick & ~stop & ~start;
  assign sub_reload = start | (advance & sub_zero);
  assign sub_dec    = advance & ~sub_zero;
  assign expire     = advance & sub_zero & (sec_left == TMO_W'(1));

  // Sub-second divider only exists when a second spans several ticks.
  generate
    if (TICKS_PER_SEC > 1) begin : g_sub
      localparam int SUB_W = $clog2(TICKS_PER_SEC);
      localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);
      logic [SUB_W-1:0] sub_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)          sub_cnt <= '0;
        else if (sub_reload) sub_cnt <= SUB_LAST;
        else if (sub_dec)    sub_cnt <= sub_cnt - SUB_W'(1);
      end
      assign sub_zero = (sub_cnt == '0);
    end else begin : g_nosub
      assign sub_zero = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      sec_left <= '0;
    end else if (stop) begin
      running  <= 1'b0;
    end else if (start) begin
      running  <= 1'b1;
      sec_left <= start_sec;
    end else if (advance && sub_zero) begin
      if (sec_left == TMO_W'(1)) running  <= 1'b0;
      else                       sec_left <= sec_left - TMO_W'(1);
    end
  end

endmodule

// File: rtl/fcrw_pulse.sv
module fcrw_pulse #(
  parameter int PULSE_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fire,
  output logic active
);

  localparam int CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                    remain <= '0;
    else if (fire)                 remain <= CNT_LOAD;
    else if (tick && remain != '0) remain <= remain - CNT_W'(1);
  end

  assign active = (remain != '0);

endmodule

// File: rtl/fcrw_code_sel.sv
module fcrw_code_sel
  import fcrw_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              rollback,
  input  logic              keep_soft,
  input  logic [CODE_W-1:0] hw_code,
  input  logic [CODE_W-1:0] sw_code,
  output logic              use_sw,
  output logic [CODE_W-1:0] freq_code
);

  code_src_e         src;
  logic [CODE_W-1:0] held_sw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src     <= SRC_STRAP;
      held_sw <= '0;
    end else if (capture) begin
      src     <= SRC_SOFT;
      held_sw <= sw_code;
    end else if (rollback) begin
      src     <= rollback_src(keep_soft);
    end
  end

  assign use_sw    = (src == SRC_SOFT);
  assign freq_code = use_sw ? held_sw : hw_code;

endmodule

// File: rtl/fcr_watchdog.sv
module fcr_watchdog #(
  parameter int CODE_W        = 5,
  parameter int TMO_W         = 4,
  parameter int TICKS_PER_SEC = 1000,
  parameter int PULSE_TICKS   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TMO_W-1:0]  tmo_field,
  input  logic              revert_last,
  input  logic              sel_write,
  input  logic              prog_enable,
  input  logic [CODE_W-1:0] hw_code,
  input  logic [CODE_W-1:0] sw_code,
  output logic              rst_pulldown,
  output logic              alarm,
  output logic              use_sw,
  output logic [CODE_W-1:0] freq_code
);

  logic change_evt;
  logic field_off;
  logic arm;
  logic expire;
  logic running;

  assign change_evt = sel_write | prog_enable;
  assign field_off  = (tmo_field == '0);
  assign arm        = change_evt & ~field_off;

  fcrw_countdown #(
    .TMO_W        (TMO_W),
    .TICKS_PER_SEC(TICKS_PER_SEC)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start    (arm),
    .stop     (field_off),
    .start_sec(tmo_field),
    .running  (running),
    .expire   (expire)
  );

  fcrw_pulse #(
    .PULSE_TICKS(PULSE_TICKS)
  ) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .fire  (expire),
    .active(rst_pulldown)
  );

  fcrw_code_sel #(
    .CODE_W(CODE_W)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (change_evt),
    .rollback (expire),
    .keep_soft(revert_last),
    .hw_code  (hw_code),
    .sw_code  (sw_code),
    .use_sw   (use_sw),
    .freq_code(freq_code)
  );

  // Alarm: set by expiry, cleared when software zeroes the field.
  always_ff @(posedge clk) begin
    if (!rst_n)         alarm <= 1'b0;
    else if (field_off) alarm <= 1'b0;
    else if (expire)    alarm <= 1'b1;
  end

endmodule

// File: rtl/fcrw_checker.sv
module fcrw_checker #(
  parameter int TMO_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [TMO_W-1:0] tmo_field,
  input logic             revert_last,
  input logic             sel_write,
  input logic             prog_enable,
  input logic             rst_pulldown,
  input logic             alarm,
  input logic             use_sw
);

  AST_ALARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (tmo_field == '0) |=> !alarm); // R6
  AST_ALARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (alarm && tmo_field != '0) |=> alarm); // R6
  AST_PULL_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(alarm) |-> rst_pulldown); // R7
  AST_PULL_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (rst_pulldown && !tick) |=> rst_pulldown); // R7
  AST_NO_PULSE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n) (tmo_field == '0) |=> !$rose(rst_pulldown)); // R4
  AST_EVENT_SELECTS_SW: assert property (@(posedge clk) disable iff (!rst_n) (sel_write || prog_enable) |=> use_sw); // R5
  AST_ROLLBACK_POLICY: assert property (@(posedge clk) disable iff (!rst_n) $rose(alarm) |-> (use_sw == $past(revert_last))); // R8

endmodule

bind fcr_watchdog fcrw_checker #(.TMO_W(TMO_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .tmo_field   (tmo_field),
  .revert_last (revert_last),
  .sel_write   (sel_write),
  .prog_enable (prog_enable),
  .rst_pulldown(rst_pulldown),
  .alarm       (alarm),
  .use_sw      (use_sw)
);

// File: tb/fcr_watchdog_tb_top.sv
module fcr_watchdog_tb_top;

  localparam int CODE_W = 5;
  localparam int TMO_W  = 4;
  localparam int TPS    = 4;
  localparam int PLS    = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [TMO_W-1:0]  tmo_field = '0;
  logic              revert_last = 1'b0;
  logic              sel_write = 1'b0;
  logic              prog_enable = 1'b0;
  logic [CODE_W-1:0] hw_code = 5'h0A;
  logic [CODE_W-1:0] sw_code = '0;
  logic              rst_pulldown;
  logic              alarm;
  logic              use_sw;
  logic [CODE_W-1:0] freq_code;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  fcr_watchdog #(
    .CODE_W(CODE_W), .TMO_W(TMO_W), .TICKS_PER_SEC(TPS), .PULSE_TICKS(PLS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tmo_field(tmo_field),
    .revert_last(revert_last), .sel_write(sel_write), .prog_enable(prog_enable),
    .hw_code(hw_code), .sw_code(sw_code), .rst_pulldown(rst_pulldown),
    .alarm(alarm), .use_sw(use_sw), .freq_code(freq_code)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick1();
    tick = 1'b1;
    step();
    tick = 1'b0;
    step();
  endtask

  task automatic event_pulse(input bit use_prog, input logic [CODE_W-1:0] code);
    sw_code = code;
    if (use_prog) prog_enable = 1'b1;
    else          sel_write   = 1'b1;
    step();
    sel_write   = 1'b0;
    prog_enable = 1'b0;
  endtask

  // Ticks until rst_pulldown rises, up to limit; returns limit+1 if never.
  task automatic ticks_to_pull(input int limit, output int n);
    n = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      tick1();
      if (rst_pulldown) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic ticks_to_release(input int limit, output int n);
    n = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      tick1();
      if (!rst_pulldown) begin
        n = i;
        break;
      end
    end
  endtask

  initial begin
    int n;
    int seen;
    logic [CODE_W-1:0] cap;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(rst_pulldown == 1'b0, "R1 pulldown", rst_pulldown, 0);
    chk(alarm == 1'b0, "R1 alarm", alarm, 0);
    chk(use_sw == 1'b0, "R1 use_sw", use_sw, 0);
    chk(freq_code == hw_code, "R1 freq_code", freq_code, hw_code);

    // R2/R3/R6/R7/R8/R10 sweep over every timeout and both policies
    for (int t = 1; t <= 15; t++) begin
      for (int rv = 0; rv <= 1; rv++) begin
        hw_code     = CODE_W'(t + 3);
        cap         = hw_code ^ 5'h15;
        revert_last = rv[0];
        tmo_field   = TMO_W'(t);
        event_pulse(t % 2 == 1, cap);   // odd timeouts use prog_enable (R3)
        sw_code = ~cap;
        step();
        chk(use_sw && freq_code == cap, "R10 captured code", freq_code, cap);
        ticks_to_pull(t * TPS + 4, n);
        chk(n == t * TPS, (t % 2 == 1) ? "R3 expiry tick" : "R2 expiry tick", n, t * TPS);
        chk(alarm == 1'b1, "R6 alarm at expiry", alarm, 1);
        chk(freq_code == (rv ? cap : hw_code), "R8 rollback code", freq_code,
            rv ? cap : hw_code);
        ticks_to_release(PLS + 4, n);
        chk(n == PLS, "R7 pulse length", n, PLS);
        chk(alarm == 1'b1, "R6 alarm held", alarm, 1);
        tmo_field = '0;
        step();
        chk(alarm == 1'b0, "R6 alarm cleared", alarm, 0);
      end
    end

    // R4 disarm before expiry
    tmo_field = 4'd3;
    event_pulse(1'b0, 5'h07);
    for (int i = 0; i < 5; i++) tick1();
    tmo_field = '0;
    step();
    seen = 0;
    for (int i = 0; i < 30; i++) begin tick1(); if (rst_pulldown) seen = 1; end
    tmo_field = 4'd3;
    for (int i = 0; i < 30; i++) begin tick1(); if (rst_pulldown) seen = 1; end
    chk(seen == 0, "R4 no pulse after disarm", seen, 0);
    chk(alarm == 1'b0, "R4 no alarm", alarm, 0);
    chk(freq_code == 5'h07, "R4 new code kept", freq_code, 5'h07);

    // R5 event with field at zero
    tmo_field = '0;
    event_pulse(1'b0, 5'h19);
    tmo_field = 4'd2;
    seen = 0;
    for (int i = 0; i < 20; i++) begin tick1(); if (rst_pulldown) seen = 1; end
    chk(seen == 0, "R5 no recovery", seen, 0);
    chk(freq_code == 5'h19 && use_sw, "R5 software code", freq_code, 5'h19);

    // R9 restart while running
    revert_last = 1'b0;
    tmo_field   = 4'd2;
    event_pulse(1'b0, 5'h03);
    for (int i = 0; i < 5; i++) tick1();
    event_pulse(1'b1, 5'h04);
    ticks_to_pull(2 * TPS + 4, n);
    chk(n == 2 * TPS, "R9 restart count", n, 2 * TPS);
    chk(freq_code == hw_code, "R9 rollback to hw", freq_code, hw_code);

    report();
  end

endmodule